// File: doc/BRIEF.md
# Dual-Group Latched Power Sequencer

This block brings up four supply rails, split into a first group (rails A and B) and a second group (rails C and D). Each group has its own active-low enable input and its own active-low group reset output. The block starts only when both enables are asserted and all four undervoltage flags report good. After a fixed stabilisation wait, it turns the rails on strictly in the order A, B, C, D. Each rail waits for the previous rail's power-good status plus its own programmable delay before it is enabled. Each group's reset is released a fixed number of cycles after that group's second rail reports power-good.

An undervoltage fault on any rail turns off only that rail's group. The group's two rail enables drop and its reset is pulled low at once. The group then stays off, and does not restart, until its own enable has been released and asserted again. The other group keeps running and does not notice. An orderly shutdown is requested by releasing both enables. Each group then reset-gates first and turns its rails off in the reverse of the turn-on order: B before A, and D before C. Each step waits for the later rail's power-low status and a programmable off-delay. Analog thresholds and capacitor timing are modelled as cycle counts and status inputs.

Top module: `pwrseq_dual`

## Requirements
- R1: While `rst` is high, all four rail enables and both group resets are low.
- R2: No rail is enabled before both enables are low and all four `uv_ok` bits are 1. If the last of these conditions becomes true in cycle n, rail A's enable (`rail_en[0]`) is high from cycle n+START_CYC+ON_DLY_A+2.
- R3: Rails turn on in the order A, B, C, D (`rail_en` bits 0..3). If the previous rail's `pgood` bit is first high in cycle p, rail B, C or D is enabled from cycle p+ON_DLY_x+2.
- R4: A group reset is high only while both rails of that group are enabled. It rises in cycle p+RESET_CYC+2, where p is the first cycle in which the group's second rail (B for `rst_ab_n`, D for `rst_cd_n`) reports `pgood`.
- R5: If a `uv_ok` bit of an active group goes low in cycle n, then in cycle n+1 both rail enables of that group and its reset are low. The other group's enables and reset are unchanged.
- R6: A faulted group stays off, even after its `uv_ok` bits return to 1, for as long as its enable stays low.
- R7: Once its enable has been high and is driven low again in cycle n, a faulted group restarts. Its first rail (A or C) is enabled from cycle n+START_CYC+ON_DLY_x+2, with the R3 and R4 timing after that. The running group is unaffected.
- R8: Releasing only one enable does not shut down running groups.
- R9: When both enables go high in cycle n, both resets are low in cycle n+1. Rails B and D turn off in cycle n+OFF_DLY_x+2. Rails A and C turn off in cycle q+OFF_DLY_x+2, where q is the first cycle in which `plow` of B or D, respectively, is high.
- R10: If a fault and the release of both enables arrive in the same cycle, the faulted group turns off at once as in R5. The other group follows the orderly R9 shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_ab_n | input | 1 | Active-low enable of group A/B |
| en_cd_n | input | 1 | Active-low enable of group C/D |
| uv_ok | input | 4 | Undervoltage status per rail (bit 0 = A ... bit 3 = D), 1 = good |
| pgood | input | 4 | Rail power-good status, same bit order |
| plow | input | 4 | Rail power-low (discharged) status, same bit order |
| rail_en | output | 4 | Rail enables, same bit order |
| rst_ab_n | output | 1 | Active-low reset of group A/B |
| rst_cd_n | output | 1 | Active-low reset of group C/D |

## Verification
An undervoltage fault and an orderly shutdown can land on the same clock edge. One group must then latch off immediately while the other walks through its reverse-order shutdown. The bench forces this by dropping rail A's undervoltage flag on the same edge that releases both enables. It then checks three things:
- the A/B rails and reset are low one cycle later;
- rail D is still enabled at that moment;
- D and then C turn off at the exact cycles their off-delays and power-low status call for.

Randomised rail response latencies move the power-good and power-low edges in every round, so the chained delay timing is measured against many different reference edges.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    GS_IDLE,
    GS_ARM,
    GS_ON1_DLY,
    GS_PG1_WAIT,
    GS_ON2_DLY,
    GS_PG2_WAIT,
    GS_RST_DLY,
    GS_RUN,
    GS_OFF2_DLY,
    GS_PL2_WAIT,
    GS_OFF1_DLY,
    GS_PL1_WAIT,
    GS_LATCHED
  } grp_state_e;

  // States in which an orderly shutdown request is honoured.
  function automatic logic is_up_state(grp_state_e s);
    return (s == GS_ON1_DLY) || (s == GS_PG1_WAIT) || (s == GS_ON2_DLY) ||
           (s == GS_PG2_WAIT) || (s == GS_RST_DLY) || (s == GS_RUN);
  endfunction

endpackage

// File: rtl/pwrseq_start_timer.sv
module pwrseq_start_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned START_CYC = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_ab_n,
  input  logic       en_cd_n,
  input  logic [3:0] uv_ok,
  output logic       ready
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(START_CYC);

  logic             cond;
  logic [CNT_W-1:0] cnt_q;

  // Start qualification: both enables low and every rail free of undervoltage.
  assign cond  = !en_ab_n && !en_cd_n && (&uv_ok);
  assign ready = cond && (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!cond) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwrseq_group.sv
module pwrseq_group
  import pwrseq_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned ON1_DLY  = 3,
  parameter int unsigned ON2_DLY  = 5,
  parameter int unsigned OFF1_DLY = 2,
  parameter int unsigned OFF2_DLY = 3,
  parameter int unsigned RST_DLY  = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_n,
  input  logic       ready,
  input  logic       stop_req,
  input  logic [1:0] uv_ok,
  input  logic       prev_good,
  input  logic [1:0] pgood,
  input  logic [1:0] plow,
  output logic [1:0] rail_en,
  output logic       grp_rst_n
);

  localparam logic [CNT_W-1:0] L_ON1  = CNT_W'(ON1_DLY);
  localparam logic [CNT_W-1:0] L_ON2  = CNT_W'(ON2_DLY);
  localparam logic [CNT_W-1:0] L_OFF1 = CNT_W'(OFF1_DLY);
  localparam logic [CNT_W-1:0] L_OFF2 = CNT_W'(OFF2_DLY);
  localparam logic [CNT_W-1:0] L_RST  = CNT_W'(RST_DLY);

  grp_state_e       st_q, nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             dly_done;
  logic             fault;
  logic [1:0]       rail_q;
  logic             rst_q;

  always_comb begin
    case (st_q)
      GS_ON1_DLY:  lim = L_ON1;
      GS_ON2_DLY:  lim = L_ON2;
      GS_RST_DLY:  lim = L_RST;
      GS_OFF2_DLY: lim = L_OFF2;
      GS_OFF1_DLY: lim = L_OFF1;
      default:     lim = '0;
    endcase
  end

  assign dly_done = (cnt_q == lim);
  assign fault    = (st_q != GS_IDLE) && (st_q != GS_LATCHED) && !(&uv_ok);

  always_comb begin
    nxt = st_q;
    if (fault) begin
      nxt = GS_LATCHED;
    end else if (is_up_state(st_q) && stop_req) begin
      nxt = GS_OFF2_DLY;
    end else begin
      case (st_q)
        GS_IDLE:     if (ready && !en_n) nxt = prev_good ? GS_ON1_DLY : GS_ARM;
        GS_ARM:      if (stop_req) nxt = GS_IDLE;
                     else if (prev_good) nxt = GS_ON1_DLY;
        GS_ON1_DLY:  if (dly_done) nxt = GS_PG1_WAIT;
        GS_PG1_WAIT: if (pgood[0]) nxt = GS_ON2_DLY;
        GS_ON2_DLY:  if (dly_done) nxt = GS_PG2_WAIT;
        GS_PG2_WAIT: if (pgood[1]) nxt = GS_RST_DLY;
        GS_RST_DLY:  if (dly_done) nxt = GS_RUN;
        GS_RUN:      nxt = GS_RUN;
        GS_OFF2_DLY: if (dly_done) nxt = GS_PL2_WAIT;
        GS_PL2_WAIT: if (plow[1]) nxt = GS_OFF1_DLY;
        GS_OFF1_DLY: if (dly_done) nxt = GS_PL1_WAIT;
        GS_PL1_WAIT: if (plow[0]) nxt = GS_IDLE;
        GS_LATCHED:  if (en_n) nxt = GS_IDLE;
        default:     nxt = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= GS_IDLE;
      cnt_q  <= '0;
      rail_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      st_q <= nxt;
      if (nxt != st_q) begin
        cnt_q <= '0;
      end else if (!dly_done) begin
        cnt_q <= cnt_q + 1'b1;
      end
      rst_q <= (nxt == GS_RUN);
      if (nxt == GS_LATCHED) begin
        rail_q <= 2'b00;
      end else begin
        if (st_q == GS_ON1_DLY  && nxt == GS_PG1_WAIT) rail_q[0] <= 1'b1;
        if (st_q == GS_ON2_DLY  && nxt == GS_PG2_WAIT) rail_q[1] <= 1'b1;
        if (st_q == GS_OFF2_DLY && nxt == GS_PL2_WAIT) rail_q[1] <= 1'b0;
        if (st_q == GS_OFF1_DLY && nxt == GS_PL1_WAIT) rail_q[0] <= 1'b0;
      end
    end
  end

  assign rail_en   = rail_q;
  assign grp_rst_n = rst_q;

endmodule

// File: rtl/pwrseq_dual.sv
module pwrseq_dual #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned START_CYC = 20,
  parameter int unsigned RESET_CYC = 30,
  parameter int unsigned ON_DLY_A  = 3,
  parameter int unsigned ON_DLY_B  = 5,
  parameter int unsigned ON_DLY_C  = 2,
  parameter int unsigned ON_DLY_D  = 4,
  parameter int unsigned OFF_DLY_A = 2,
  parameter int unsigned OFF_DLY_B = 3,
  parameter int unsigned OFF_DLY_C = 4,
  parameter int unsigned OFF_DLY_D = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_ab_n,
  input  logic       en_cd_n,
  input  logic [3:0] uv_ok,
  input  logic [3:0] pgood,
  input  logic [3:0] plow,
  output logic [3:0] rail_en,
  output logic       rst_ab_n,
  output logic       rst_cd_n
);

  localparam int unsigned N_GRP = 2;

  logic             ready;
  logic             stop_req;
  logic [N_GRP-1:0] grp_en_n;
  logic [N_GRP-1:0] chain_ok;
  logic [N_GRP-1:0] grp_rst;
  logic [3:0]       rail_w;

  assign stop_req    = en_ab_n & en_cd_n;
  assign grp_en_n    = {en_cd_n, en_ab_n};
  // Group A/B leads; group C/D may only begin once rail B is up and good.
  assign chain_ok[0] = 1'b1;
  assign chain_ok[1] = rail_w[1] & pgood[1];

  pwrseq_start_timer #(
    .CNT_W    (CNT_W),
    .START_CYC(START_CYC)
  ) start_i (
    .clk    (clk),
    .rst    (rst),
    .en_ab_n(en_ab_n),
    .en_cd_n(en_cd_n),
    .uv_ok  (uv_ok),
    .ready  (ready)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int unsigned G_ON1  = (g == 0) ? ON_DLY_A  : ON_DLY_C;
    localparam int unsigned G_ON2  = (g == 0) ? ON_DLY_B  : ON_DLY_D;
    localparam int unsigned G_OFF1 = (g == 0) ? OFF_DLY_A : OFF_DLY_C;
    localparam int unsigned G_OFF2 = (g == 0) ? OFF_DLY_B : OFF_DLY_D;

    pwrseq_group #(
      .CNT_W   (CNT_W),
      .ON1_DLY (G_ON1),
      .ON2_DLY (G_ON2),
      .OFF1_DLY(G_OFF1),
      .OFF2_DLY(G_OFF2),
      .RST_DLY (RESET_CYC)
    ) grp_i (
      .clk      (clk),
      .rst      (rst),
      .en_n     (grp_en_n[g]),
      .ready    (ready),
      .stop_req (stop_req),
      .uv_ok    (uv_ok[2*g+1 -: 2]),
      .prev_good(chain_ok[g]),
      .pgood    (pgood[2*g+1 -: 2]),
      .plow     (plow[2*g+1 -: 2]),
      .rail_en  (rail_w[2*g+1 -: 2]),
      .grp_rst_n(grp_rst[g])
    );
  end

  assign rail_en  = rail_w;
  assign rst_ab_n = grp_rst[0];
  assign rst_cd_n = grp_rst[1];

endmodule

// File: rtl/pwrseq_dual_chk.sv
module pwrseq_dual_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] uv_ok,
  input logic [3:0] rail_en,
  input logic       rst_ab_n,
  input logic       rst_cd_n
);

  // R5: a flagged rail in a live A/B group kills both A/B rails and its reset next cycle
  a_r5_fault_ab: assert property (@(posedge clk) disable iff (rst)
    (!(&uv_ok[1:0]) && (rail_en[1:0] != 2'b00)) |=> (rail_en[1:0] == 2'b00 && !rst_ab_n));

  // R5: same for group C/D
  a_r5_fault_cd: assert property (@(posedge clk) disable iff (rst)
    (!(&uv_ok[3:2]) && (rail_en[3:2] != 2'b00)) |=> (rail_en[3:2] == 2'b00 && !rst_cd_n));

  // R3: the second rail of a group never comes up ahead of the first
  a_r3_order_ab: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en[1]) |-> rail_en[0]);

  a_r3_order_cd: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_en[3]) |-> rail_en[2]);

  // R9: the first rail of a group never goes down while the second is still up
  a_r9_reverse_ab: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en[0]) |-> !rail_en[1]);

  a_r9_reverse_cd: assert property (@(posedge clk) disable iff (rst)
    $fell(rail_en[2]) |-> !rail_en[3]);

  // R4: a released group reset implies both group rails are enabled
  a_r4_rst_ab: assert property (@(posedge clk) disable iff (rst)
    rst_ab_n |-> (rail_en[1:0] == 2'b11));

  a_r4_rst_cd: assert property (@(posedge clk) disable iff (rst)
    rst_cd_n |-> (rail_en[3:2] == 2'b11));

endmodule

bind pwrseq_dual pwrseq_dual_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .uv_ok   (uv_ok),
  .rail_en (rail_en),
  .rst_ab_n(rst_ab_n),
  .rst_cd_n(rst_cd_n)
);

// File: tb/pwrseq_dual_tb.sv
module pwrseq_dual_tb_top;

  localparam int S_CYC = 20;
  localparam int R_CYC = 30;
  localparam int ON_A = 3, ON_B = 5, ON_C = 2, ON_D = 4;
  localparam int OF_A = 2, OF_B = 3, OF_C = 4, OF_D = 1;
  localparam int WD_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic       en_ab_n, en_cd_n;
  logic [3:0] uv_ok;
  logic [3:0] pgood, plow;
  logic [3:0] rail_en;
  logic       rst_ab_n, rst_cd_n;

  int tick = 0;
  int total = 0;
  int bad = 0;
  int on_d[4]  = '{ON_A, ON_B, ON_C, ON_D};
  int off_d[4] = '{OF_A, OF_B, OF_C, OF_D};
  int lat[4];
  int onc[4], offc[4];
  int t_en_r[4], t_en_f[4], t_pg_r[4], t_pl_r[4], t_rst_r[2];
  logic [3:0] en_prev;
  logic [1:0] rst_prev;

  always #4 clk = ~clk;
  always @(posedge clk) tick <= tick + 1;

  pwrseq_dual #(
    .CNT_W(16), .START_CYC(S_CYC), .RESET_CYC(R_CYC),
    .ON_DLY_A(ON_A), .ON_DLY_B(ON_B), .ON_DLY_C(ON_C), .ON_DLY_D(ON_D),
    .OFF_DLY_A(OF_A), .OFF_DLY_B(OF_B), .OFF_DLY_C(OF_C), .OFF_DLY_D(OF_D)
  ) dut_i (
    .clk(clk), .rst(rst), .en_ab_n(en_ab_n), .en_cd_n(en_cd_n),
    .uv_ok(uv_ok), .pgood(pgood), .plow(plow), .rail_en(rail_en),
    .rst_ab_n(rst_ab_n), .rst_cd_n(rst_cd_n)
  );

  // Event recorder plus rail model: power-good follows an enable after lat cycles,
  // power-low follows a disable after lat cycles.
  always @(negedge clk) begin
    if (rst) begin
      pgood = 4'b0000;
      plow  = 4'b1111;
      en_prev = 4'b0000;
      rst_prev = 2'b00;
      for (int i = 0; i < 4; i++) begin
        onc[i] = 0;
        offc[i] = 0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (rail_en[i] && !en_prev[i]) t_en_r[i] = tick;
        if (!rail_en[i] && en_prev[i]) t_en_f[i] = tick;
        en_prev[i] = rail_en[i];
        if (rail_en[i]) begin
          offc[i] = 0;
          plow[i] = 1'b0;
          if (onc[i] < lat[i]) onc[i]++;
          else if (!pgood[i]) begin
            pgood[i] = 1'b1;
            t_pg_r[i] = tick;
          end
        end else begin
          onc[i] = 0;
          pgood[i] = 1'b0;
          if (offc[i] < lat[i]) offc[i]++;
          else if (!plow[i]) begin
            plow[i] = 1'b1;
            t_pl_r[i] = tick;
          end
        end
      end
      if (rst_ab_n && !rst_prev[0]) t_rst_r[0] = tick;
      if (rst_cd_n && !rst_prev[1]) t_rst_r[1] = tick;
      rst_prev = {rst_cd_n, rst_ab_n};
    end
  end

  function automatic int exp_after(input int t_ref, input int dly);
    return t_ref + dly + 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input int g, input logic v);
    if (g == 0) en_ab_n = v;
    else en_cd_n = v;
  endtask

  task automatic start_all(input bool_gate);
    int n0;
    int uvb;
    @(negedge clk);
    en_ab_n = 1'b0;
    if (bool_gate) begin
      uvb = $urandom % 4;
      uv_ok[uvb] = 1'b0;
    end
    wait_n(1 + $urandom % 6);
    en_cd_n = 1'b0;
    n0 = tick;
    if (bool_gate) begin
      wait_n(S_CYC + 15);
      chk("R2 held off by undervoltage", int'(rail_en), 0);
      uv_ok = 4'hF;
      n0 = tick;
    end
    wait_n(200);
    chk("R2 rail A start", t_en_r[0], exp_after(n0, S_CYC + ON_A));
    for (int i = 1; i < 4; i++)
      chk("R3 chained rail start", t_en_r[i], exp_after(t_pg_r[i-1], on_d[i]));
    chk("R4 reset A/B release", t_rst_r[0], exp_after(t_pg_r[1], R_CYC));
    chk("R4 reset C/D release", t_rst_r[1], exp_after(t_pg_r[3], R_CYC));
  endtask

  task automatic run_all();
    int n0;
    int g, fr, fg, og;
    rst = 1'b1; en_ab_n = 1'b1; en_cd_n = 1'b1; uv_ok = 4'hF;
    wait_n(5);
    chk("R1 reset rails", int'(rail_en), 0);
    chk("R1 reset outputs", int'({rst_cd_n, rst_ab_n}), 0);
    @(negedge clk);
    rst = 1'b0;
    wait_n(12);
    for (int it = 0; it < 3; it++) begin
      for (int i = 0; i < 4; i++) lat[i] = 1 + $urandom % 6;
      start_all(it == 0);
      // R8: a single released enable leaves everything running
      g = $urandom % 2;
      @(negedge clk);
      set_en(g, 1'b1);
      wait_n(5 + $urandom % 35);
      chk("R8 rails kept on", int'(rail_en), 15);
      chk("R8 resets kept high", int'({rst_cd_n, rst_ab_n}), 3);
      set_en(g, 1'b0);
      wait_n(3);
      // R5/R6/R7: fault on a random rail
      fr = $urandom % 4;
      fg = fr / 2;
      og = 1 - fg;
      @(negedge clk);
      uv_ok[fr] = 1'b0;
      @(negedge clk);
      chk("R5 faulted group rails off", int'(rail_en[2*fg +: 2]), 0);
      chk("R5 faulted group reset low", int'(fg == 0 ? rst_ab_n : rst_cd_n), 0);
      chk("R5 other group rails on", int'(rail_en[2*og +: 2]), 3);
      chk("R5 other group reset high", int'(og == 0 ? rst_ab_n : rst_cd_n), 1);
      uv_ok = 4'hF;
      wait_n(3 * S_CYC);
      chk("R6 latched off", int'(rail_en[2*fg +: 2]), 0);
      set_en(fg, 1'b1);
      wait_n(3);
      set_en(fg, 1'b0);
      n0 = tick;
      wait_n(200);
      chk("R7 restart first rail", t_en_r[2*fg], exp_after(n0, S_CYC + on_d[2*fg]));
      chk("R7 restart second rail", t_en_r[2*fg+1], exp_after(t_pg_r[2*fg], on_d[2*fg+1]));
      chk("R7 restart reset", t_rst_r[fg], exp_after(t_pg_r[2*fg+1], R_CYC));
      chk("R7 other group undisturbed", int'({rst_cd_n, rst_ab_n, rail_en}), 63);
      // R9: orderly shutdown
      @(negedge clk);
      en_ab_n = 1'b1; en_cd_n = 1'b1;
      n0 = tick;
      @(negedge clk);
      chk("R9 resets low", int'({rst_cd_n, rst_ab_n}), 0);
      wait_n(200);
      chk("R9 rail B off", t_en_f[1], exp_after(n0, OF_B));
      chk("R9 rail D off", t_en_f[3], exp_after(n0, OF_D));
      chk("R9 rail A off", t_en_f[0], exp_after(t_pl_r[1], OF_A));
      chk("R9 rail C off", t_en_f[2], exp_after(t_pl_r[3], OF_C));
    end
    // R10: fault on rail A in the same cycle as release of both enables
    start_all(1'b0);
    @(negedge clk);
    uv_ok[0] = 1'b0; en_ab_n = 1'b1; en_cd_n = 1'b1;
    n0 = tick;
    @(negedge clk);
    chk("R10 A/B off at once", int'({rst_ab_n, rail_en[1:0]}), 0);
    chk("R10 rail D still on", int'(rail_en[3]), 1);
    chk("R10 reset C/D low", int'(rst_cd_n), 0);
    uv_ok = 4'hF;
    wait_n(200);
    chk("R10 rail D orderly off", t_en_f[3], exp_after(n0, OF_D));
    chk("R10 rail C orderly off", t_en_f[2], exp_after(t_pl_r[3], OF_C));
  endtask

  initial begin
    bit wd;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4; i++) lat[i] = 2;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (WD_CYC) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYC, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule